// File: doc/BRIEF.md
# Multi-Size Configurable 1D Integer DCT

This block computes a one-dimensional integer DCT over a parallel vector of N signed samples, with N set by parameter to 4, 8 or 16 (default 16). Every lane multiplies its own sample by a coefficient that is chosen at run time. A signed binary adder tree then sums the lane products. The tree can be tapped at any level, so the same lanes can work as one N-point transform or as several independent shorter transforms on adjacent slices of the input vector.

A start pulse captures the sample vector and a size code. From the next cycle the block steps through the coefficient rows and emits one result per active transform per cycle, together with the row index. Each transform size has its own row counter, and the size code picks which counter drives the coefficient selection. Transposition and two-dimensional control belong to the surrounding logic.

Top module: `msdct_core`

## Requirements
- R1: While reset is asserted and after its release with no run, `valid_o` is 0, `row_o` is 0 and every slot of `coef_o` is 0. Outside a run all slots read 0.
- R2: Size code m gives transform size S = N >> m and 2^m independent transforms. Transform j reads lanes j·S to j·S+S−1 and reports in slot j of `coef_o`, at bits j·OW upward. Slots j ≥ 2^m read 0. Codes above log2(N)−1 act as the 2-point code.
- R3: The result for row k of an S-point transform is Σ x[n]·C_S(k,n). C_S follows the integer DCT matrix used in HEVC: row 0 is all 64, and for k > 0 the magnitude is the value from {90,89,87,83,80,75,70,64,57,50,43,36,25,18,9} nearest to 64·√2·|cos((2n+1)kπ/2S)|, with the sign of that cosine. The 4-point rows are [64 64 64 64], [83 36 −36 −83], [64 −64 −64 64] and [36 −83 83 −36].
- R4: If a start is accepted at clock edge E0, `valid_o` is 1 after edges E1 to ES and 0 after E(S+1). Row k appears after edge E(k+1) with `row_o` = k, so rows run 0 to S−1 in order.
- R5: A start that arrives while a run is in progress is ignored, including on its last busy edge. Changes on `x_i` and `mode_i` after the capture edge have no effect on the run's results, and no extra run follows.
- R6: Results are exact for any 8-bit signed input at the largest size: `coef_o` slots are OW = DW+7+log2(N) bits, two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture samples and size code, begin a run |
| mode_i | input | MW = clog2(log2 N) | Size code: 0 = N-point, each step halves the size |
| x_i | input | N·DW | Signed samples, lane n at bits n·DW upward |
| valid_o | output | 1 | Result slots hold a row result |
| row_o | output | log2 N | Row index of the current results |
| coef_o | output | (N/2)·OW | Signed result per transform, slot j at bits j·OW upward |

## Verification
A wrong row counter shows at the ports in the first output cycle as a wrong `row_o` or a wrong row's values, or as a run of the wrong length on `valid_o`. A wrong lane coefficient or tree tap corrupts the very first row that uses it, in the slot that owns that lane. Any transform with nonzero input therefore shows the fault within S cycles of the start. A lost capture register shows when a start is injected in the middle of a run: the run restarts, or it continues with the injected data.

// File: rtl/msdct_pkg.sv
`timescale 1ns/1ps
package msdct_pkg;

  // Coefficient of row k, column n for a transform of size 2**slog (slog 1..4).
  // Angles live on a grid of pi/32; smaller sizes step through it sparsely.
  function automatic logic signed [7:0] coef_of(input int k, input int n, input int slog);
    int         a;
    logic       neg;
    logic [6:0] m;
    if (k == 0) return 8'sd64;
    a   = (((2 * n + 1) * k) << (4 - slog)) & 63;
    neg = 1'b0;
    if (a > 32) a = 64 - a;
    if (a > 16) begin
      a   = 32 - a;
      neg = 1'b1;
    end
    case (a)
      0, 1:    m = 7'd90;
      2:       m = 7'd89;
      3:       m = 7'd87;
      4:       m = 7'd83;
      5:       m = 7'd80;
      6:       m = 7'd75;
      7:       m = 7'd70;
      8:       m = 7'd64;
      9:       m = 7'd57;
      10:      m = 7'd50;
      11:      m = 7'd43;
      12:      m = 7'd36;
      13:      m = 7'd25;
      14:      m = 7'd18;
      15:      m = 7'd9;
      default: m = 7'd0;
    endcase
    return neg ? -$signed({1'b0, m}) : $signed({1'b0, m});
  endfunction

endpackage

// File: rtl/msdct_lane.sv
`timescale 1ns/1ps
module msdct_lane #(
  parameter int DW   = 8,
  parameter int L    = 4,
  parameter int MW   = 2,
  parameter int LANE = 0,
  localparam int PW  = DW + 7
) (
  input  logic signed [DW-1:0] x_i,
  input  logic [MW-1:0]        mode_i,
  input  logic [L-1:0]         row_i,
  output logic signed [PW-1:0] prod_o
);

  int                 slog;
  int                 loc;
  logic signed [7:0]  coef;
  logic [6:0]         mag;
  logic [DW-1:0]      xa;
  logic               neg;
  logic [DW+5:0]      pp [7];
  logic [DW+5:0]      acc;

  always_comb begin
    slog = L - int'(mode_i);
    loc  = LANE & ((1 << slog) - 1);
    coef = msdct_pkg::coef_of(int'(row_i), loc, slog);
    mag  = coef[7] ? 7'(-coef) : 7'(coef);
    xa   = x_i[DW-1] ? DW'(-x_i) : DW'(x_i);
    neg  = x_i[DW-1] ^ coef[7];
  end

  // shifted copies of |x| selected by coefficient bits, then one sum
  for (genvar i = 0; i < 7; i++) begin : pp_g
    assign pp[i] = mag[i] ? ({6'b0, xa} << i) : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < 7; i++) acc = acc + pp[i];
    prod_o = neg ? -$signed({1'b0, acc}) : $signed({1'b0, acc});
  end

endmodule

// File: rtl/msdct_tree.sv
`timescale 1ns/1ps
module msdct_tree #(
  parameter int N  = 16,
  parameter int PW = 15,
  parameter int MW = 2,
  localparam int L  = $clog2(N),
  localparam int OW = PW + L,
  localparam int NS = N / 2
) (
  input  logic signed [PW-1:0] prod_i [N],
  input  logic [MW-1:0]        mode_i,
  output logic signed [OW-1:0] slot_o [NS]
);

  for (genvar l = 0; l <= L; l++) begin : lv
    localparam int W = N >> l;
    logic signed [OW-1:0] s [W];
    for (genvar j = 0; j < W; j++) begin : nd
      if (l == 0) begin : leaf_g
        assign s[j] = OW'(prod_i[j]);
      end else begin : add_g
        assign s[j] = lv[l-1].s[2*j] + lv[l-1].s[2*j+1];
      end
    end
  end

  // tap[l-1] holds level l padded with zero to NS slots
  logic signed [OW-1:0] tap [L][NS];
  for (genvar l = 1; l <= L; l++) begin : tap_g
    for (genvar j = 0; j < NS; j++) begin : t_g
      if (j < (N >> l)) begin : live_g
        assign tap[l-1][j] = lv[l].s[j];
      end else begin : pad_g
        assign tap[l-1][j] = '0;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NS; j++) slot_o[j] = tap[L-1-int'(mode_i)][j];
  end

endmodule

// File: rtl/msdct_rowseq.sv
`timescale 1ns/1ps
module msdct_rowseq #(
  parameter int L  = 4,
  parameter int MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] mode_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [L-1:0]  row_o
);

  logic          busy_q;
  logic          last;
  logic [L-1:0]  row_all [L];
  logic [L-1:0]  size_m1;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;

  // one up counter per transform size 2**s
  for (genvar s = 1; s <= L; s++) begin : ctr_g
    logic [s-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (accept_o) cnt_q <= '0;
      else if (busy_q)   cnt_q <= cnt_q + 1'b1;
    end
    assign row_all[s-1] = L'(cnt_q);
  end

  always_comb begin
    row_o   = row_all[L-1-int'(mode_i)];
    size_m1 = L'((1 << (L - int'(mode_i))) - 1);
    last    = busy_q && (row_o == size_m1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       busy_q <= 1'b0;
    else if (accept_o) busy_q <= 1'b1;
    else if (last)     busy_q <= 1'b0;
  end

  assert_row_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> row_o == '0);

  assert_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> row_o == $past(row_o) + L'(1));

endmodule

// File: rtl/msdct_core.sv
`timescale 1ns/1ps
module msdct_core #(
  parameter int N  = 16,
  parameter int DW = 8,
  localparam int L  = $clog2(N),
  localparam int MW = (L > 1) ? $clog2(L) : 1,
  localparam int PW = DW + 7,
  localparam int OW = PW + L,
  localparam int NS = N / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MW-1:0]     mode_i,
  input  logic [N*DW-1:0]   x_i,
  output logic              valid_o,
  output logic [L-1:0]      row_o,
  output logic [NS*OW-1:0]  coef_o
);

  logic [N*DW-1:0]      x_q;
  logic [MW-1:0]        mode_q;
  logic [MW-1:0]        mode_lim;
  logic                 accept;
  logic                 busy;
  logic [L-1:0]         act_row;
  logic signed [PW-1:0] prod [N];
  logic signed [OW-1:0] slot [NS];
  logic signed [OW-1:0] coef_q [NS];
  logic                 valid_q;
  logic [L-1:0]         row_q;

  assign mode_lim = (int'(mode_i) > L - 1) ? MW'(L - 1) : mode_i;

  msdct_rowseq #(.L(L), .MW(MW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_q),
    .accept_o (accept),
    .busy_o   (busy),
    .row_o    (act_row)
  );

  for (genvar i = 0; i < N; i++) begin : lane_g
    msdct_lane #(.DW(DW), .L(L), .MW(MW), .LANE(i)) u_lane (
      .x_i    ($signed(x_q[i*DW +: DW])),
      .mode_i (mode_q),
      .row_i  (act_row),
      .prod_o (prod[i])
    );
  end

  msdct_tree #(.N(N), .PW(PW), .MW(MW)) u_tree (
    .prod_i (prod),
    .mode_i (mode_q),
    .slot_o (slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      mode_q  <= '0;
      valid_q <= 1'b0;
      row_q   <= '0;
      for (int j = 0; j < NS; j++) coef_q[j] <= '0;
    end else begin
      if (accept) begin
        x_q    <= x_i;
        mode_q <= mode_lim;
      end
      valid_q <= busy;
      row_q   <= busy ? act_row : '0;
      for (int j = 0; j < NS; j++) coef_q[j] <= busy ? slot[j] : '0;
    end
  end

  assign valid_o = valid_q;
  assign row_o   = row_q;
  for (genvar j = 0; j < NS; j++) begin : pack_g
    assign coef_o[j*OW +: OW] = coef_q[j];
  end

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> coef_o == '0);

  assert_out_row_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) |-> row_o == $past(row_o) + L'(1));

  assert_start_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i |=> $stable(x_q) && $stable(mode_q));

  assert_mode_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable(mode_q));

endmodule

// File: tb/msdct_core_tb_top.sv
`timescale 1ns/1ps
module msdct_core_tb_top;
  localparam int CLK_NS = 10;
  localparam int N  = 16;
  localparam int DW = 8;
  localparam int L  = 4;
  localparam int MW = 2;
  localparam int OW = DW + 7 + L;
  localparam int NS = N / 2;
  localparam real PI = 3.14159265358979;
  localparam int MAGS [16] = '{90, 89, 87, 83, 80, 75, 70, 64, 57, 50, 43, 36, 25, 18, 9, 0};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [MW-1:0]     mode_i = '0;
  logic [N*DW-1:0]   x_i = '0;
  logic              valid_o;
  logic [L-1:0]      row_o;
  logic [NS*OW-1:0]  coef_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  msdct_core #(.N(N), .DW(DW)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .mode_i  (mode_i),
    .x_i     (x_i),
    .valid_o (valid_o),
    .row_o   (row_o),
    .coef_o  (coef_o)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int coef_ref(int s, int k, int n);
    real v, av, d, bd;
    int  best;
    if (k == 0) return 64;
    v  = 64.0 * $sqrt(2.0) * $cos(PI * (2 * n + 1) * k / (2.0 * s));
    av = (v < 0.0) ? -v : v;
    best = 0;
    bd = 1000.0;
    for (int i = 0; i < 16; i++) begin
      d = av - MAGS[i];
      if (d < 0.0) d = -d;
      if (d < bd) begin bd = d; best = MAGS[i]; end
    end
    return (v < 0.0) ? -best : best;
  endfunction

  function automatic longint exp_val(logic [N*DW-1:0] v, int s, int j, int r);
    longint acc = 0;
    for (int n = 0; n < s; n++)
      acc += longint'($signed(v[(j*s+n)*DW +: DW])) * coef_ref(s, r, n);
    return acc;
  endfunction

  task automatic run(int m, logic [N*DW-1:0] v, bit inj, string tag);
    int s   = N >> m;
    int cnt = 1 << m;
    @(negedge clk_i);
    mode_i  = MW'(m);
    x_i     = v;
    start_i = 1'b1;
    @(posedge clk_i); #(CLK_NS/4);
    start_i = 1'b0;
    for (int r = 0; r < s; r++) begin
      @(posedge clk_i); #(CLK_NS/4);
      chk("R4 valid during run", longint'(valid_o), 1);
      chk("R4 row index", longint'(row_o), r);
      for (int j = 0; j < NS; j++)
        chk((j < cnt) ? tag : "R2 unused slot",
            longint'($signed(coef_o[j*OW +: OW])),
            (j < cnt) ? exp_val(v, s, j, r) : 0);
      if (inj && r == 1) begin
        start_i = 1'b1;
        x_i     = ~v;
        mode_i  = MW'(m + 1);
      end
      if (inj && r == 2) start_i = 1'b0;
    end
    @(posedge clk_i); #(CLK_NS/4);
    chk("R4 valid after run", longint'(valid_o), 0);
    chk("R1 idle slots zero", longint'(coef_o != '0), 0);
    if (inj) begin
      @(posedge clk_i); #(CLK_NS/4);
      chk("R5 no restart", longint'(valid_o), 0);
    end
  endtask

  initial begin
    logic [N*DW-1:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #(CLK_NS/4);
    chk("R1 valid in reset", longint'(valid_o), 0);
    chk("R1 slots in reset", longint'(coef_o != '0), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #(CLK_NS/4);
    chk("R1 valid after reset", longint'(valid_o), 0);
    chk("R1 row after reset", longint'(row_o), 0);
    chk("R1 slots after reset", longint'(coef_o != '0), 0);

    for (int n = 0; n < N; n++) v[n*DW +: DW] = 8'sd127;
    run(0, v, 1'b0, "R6 all max");
    for (int n = 0; n < N; n++) v[n*DW +: DW] = -8'sd128;
    run(0, v, 1'b0, "R6 all min");
    for (int n = 0; n < N; n++) v[n*DW +: DW] = (n < N/2) ? 8'sd127 : -8'sd128;
    run(0, v, 1'b0, "R6 split extremes");
    for (int n = 0; n < N; n++) v[n*DW +: DW] = (n % 2 == 0) ? -8'sd128 : 8'sd127;
    run(1, v, 1'b0, "R2 8-point extremes");
    for (int n = 0; n < N; n++) v[n*DW +: DW] = (n == 5) ? 8'sd1 : 8'sd0;
    run(2, v, 1'b0, "R3 4-point impulse");
    for (int n = 0; n < N; n++) v[n*DW +: DW] = DW'(n + 1);
    run(3, v, 1'b0, "R2 2-point ramp");
    for (int n = 0; n < N; n++) v[n*DW +: DW] = DW'($urandom());
    run(0, v, 1'b1, "R5 start mid-run");
    for (int n = 0; n < N; n++) v[n*DW +: DW] = DW'($urandom());
    run(2, v, 1'b1, "R5 start mid-run 4-point");

    for (int t = 0; t < 20; t++) begin
      int m = $urandom_range(0, L - 1);
      for (int n = 0; n < N; n++) v[n*DW +: DW] = DW'($urandom());
      run(m, v, 1'b0, (m == 0) ? "R3 random full" : "R2 random split");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule